// File: doc/BRIEF.md
# Byte FIFO with Watermark Alerts

This block is a 64-entry byte queue that sits between a host register interface and an internal command engine. Both sides can push bytes into it and pop bytes from it. The host sees the current fill count, a sticky overflow flag and two alerts that derive from a single programmable water level. A near-full alert fires when little free space remains. A near-empty alert fires when few bytes are stored. Each alert has its own enable, and the enabled alerts combine into one interrupt output. A flush pulse empties the queue at once.

A small command-tracking state machine sets what the host may do. It has three states. In `CMD_IDLE` no command runs, and the host may read and write. In `CMD_ARGLOAD` an argument-loading command runs, and the host may only write. In `CMD_STREAM` a data-moving command runs, and the host may read and write. From `CMD_IDLE`, a `cmd_start` pulse with kind `2'b01` takes the transition `T_LOAD` to `CMD_ARGLOAD`. The same pulse with kind `2'b10` takes `T_STREAM` to `CMD_STREAM`. Any other kind, or a start pulse in a busy state, is ignored. A `cmd_done` pulse in either busy state takes `T_DONE` back to `CMD_IDLE`.

Top module: `wmfifo_top`

## Requirements
- R1: After reset the fill count is 0, overflow is 0, the command state is `CMD_IDLE`, the near-empty alert is 1 and the near-full alert is 0.
- R2: Accepted bytes leave in the order they were written, and `fill_count` (7 bits, 0 to 64) equals the number of bytes held.
- R3: A `flush` pulse sets the fill count to 0 and clears overflow. Bytes held before the flush are no longer returned, and 64 new bytes can then be written. Flush overrides any access made in the same cycle.
- R4: A write while 64 bytes are held, with no pop in the same cycle, is discarded and sets `overflow`. The flag stays at 1 until a flush.
- R5: A pop while the queue is empty returns 8'h00 and changes neither the pointers nor the count.
- R6: A push and a pop in the same cycle change the count by the net amount. When the queue is full, both are accepted, the count stays at 64 and no overflow is raised. When the queue is empty, only the push takes effect.
- R7: `hi_alert` is 1 exactly when (64 − fill_count) ≤ `water_level`.
- R8: `lo_alert` is 1 exactly when fill_count ≤ `water_level`.
- R9: `irq` = (`lo_irq_en` AND `lo_alert`) OR (`hi_irq_en` AND `hi_alert`), and it follows an enable change within the same cycle.
- R10: The command state follows the transitions `T_LOAD` (kind 2'b01), `T_STREAM` (kind 2'b10) and `T_DONE`. A start pulse with another kind, or a start pulse outside `CMD_IDLE`, leaves the state unchanged.
- R11: In `CMD_ARGLOAD`, host pushes are accepted. A host pop is ignored: it returns 8'h00 and moves no pointer.
- R12: When the engine and the host request the same direction in the same cycle, the engine's access wins. The host access is dropped: its byte is not stored, or its read returns 8'h00.
- R13: The count and all flags take their new values one clock edge after the access, and the flags change in the same cycle as the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the queue and clear overflow |
| cmd_start | input | 1 | Command begins (pulse) |
| cmd_kind | input | 2 | Command kind at start: 01 argument load, 10 stream |
| cmd_done | input | 1 | Command ends (pulse) |
| host_wr | input | 1 | Host push request |
| host_wdata | input | 8 | Host push byte |
| host_rd | input | 1 | Host pop request |
| host_rdata | output | 8 | Head byte for a granted host pop, else 0 |
| eng_wr | input | 1 | Engine push request |
| eng_wdata | input | 8 | Engine push byte |
| eng_rd | input | 1 | Engine pop request |
| eng_rdata | output | 8 | Head byte, 0 when empty |
| water_level | input | 6 | Alert threshold |
| lo_irq_en | input | 1 | Near-empty interrupt enable |
| hi_irq_en | input | 1 | Near-full interrupt enable |
| fill_count | output | 7 | Bytes held |
| overflow | output | 1 | Sticky overflow flag |
| hi_alert | output | 1 | Near-full alert |
| lo_alert | output | 1 | Near-empty alert |
| irq | output | 1 | Combined interrupt |

## Verification
Read data is combinational from the head entry, so the bench samples it one time unit after driving a pop, before the clock edge that removes the byte. The count, overflow and both alerts are due one edge after the access, so each is sampled one time unit after that edge. A command pulse changes the permissions from the next cycle onward. The interrupt responds to an enable change in the same cycle, so the bench samples it just after changing the enable, with no clock edge in between.

// File: rtl/wmfifo_pkg.sv
package wmfifo_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE    = 2'd0,
        CMD_ARGLOAD = 2'd1,
        CMD_STREAM  = 2'd2
    } cmd_state_e;

    localparam logic [1:0] KIND_ARGLOAD = 2'b01;
    localparam logic [1:0] KIND_STREAM  = 2'b10;
endpackage

// File: rtl/wmfifo_access.sv
module wmfifo_access
    import wmfifo_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic [1:0]    cmd_kind,
    input  logic          cmd_done,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    input  logic          eng_wr,
    input  logic [DW-1:0] eng_wdata,
    input  logic          eng_rd,
    input  logic [DW-1:0] head_data,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          rd_en,
    output logic [DW-1:0] host_rdata
);
    cmd_state_e state_q, state_d;
    logic host_rd_perm, host_wr_perm;
    logic host_rd_grant, host_wr_grant;

    // next-state logic: T_LOAD, T_STREAM, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: begin
                if (cmd_start && cmd_kind == KIND_ARGLOAD)
                    state_d = CMD_ARGLOAD;
                else if (cmd_start && cmd_kind == KIND_STREAM)
                    state_d = CMD_STREAM;
            end
            CMD_ARGLOAD: if (cmd_done) state_d = CMD_IDLE;
            CMD_STREAM:  if (cmd_done) state_d = CMD_IDLE;
            default:     state_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    // permission outputs per state
    always_comb begin
        host_rd_perm = 1'b0;
        host_wr_perm = 1'b0;
        unique case (state_q)
            CMD_IDLE:    begin host_rd_perm = 1'b1; host_wr_perm = 1'b1; end
            CMD_ARGLOAD: begin host_rd_perm = 1'b0; host_wr_perm = 1'b1; end
            CMD_STREAM:  begin host_rd_perm = 1'b1; host_wr_perm = 1'b1; end
            default:     begin host_rd_perm = 1'b0; host_wr_perm = 1'b0; end
        endcase
    end

    // engine wins a direction over the host
    assign host_wr_grant = host_wr && host_wr_perm && !eng_wr;
    assign host_rd_grant = host_rd && host_rd_perm && !eng_rd;

    assign wr_en      = eng_wr || host_wr_grant;
    assign wr_data    = eng_wr ? eng_wdata : host_wdata;
    assign rd_en      = eng_rd || host_rd_grant;
    assign host_rdata = host_rd_grant ? head_data : '0;
endmodule

// File: rtl/wmfifo_store.sv
module wmfifo_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count,
    output logic          overflow
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, empty, do_wr, do_rd;

    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);
    assign do_rd = rd_en && !empty;
    assign do_wr = wr_en && (!full || do_rd);

    assign head_data = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr && !flush) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else if (flush) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            if (do_wr && !do_rd)      count <= count + 1'b1;
            else if (do_rd && !do_wr) count <= count - 1'b1;
            if (wr_en && !do_wr) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/wmfifo_status.sv
module wmfifo_status #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] water_level,
    input  logic          lo_irq_en,
    input  logic          hi_irq_en,
    output logic          hi_alert,
    output logic          lo_alert,
    output logic          irq
);
    logic [CW-1:0] free_space, level_ext;

    assign free_space = CW'(DEPTH) - count;
    assign level_ext  = CW'(water_level);
    assign hi_alert   = (free_space <= level_ext);
    assign lo_alert   = (count <= level_ext);
    assign irq        = (lo_irq_en && lo_alert) || (hi_irq_en && hi_alert);
endmodule

// File: rtl/wmfifo_top.sv
module wmfifo_top #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          cmd_start,
    input  logic [1:0]    cmd_kind,
    input  logic          cmd_done,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    input  logic          eng_wr,
    input  logic [DW-1:0] eng_wdata,
    input  logic          eng_rd,
    output logic [DW-1:0] eng_rdata,
    input  logic [AW-1:0] water_level,
    input  logic          lo_irq_en,
    input  logic          hi_irq_en,
    output logic [CW-1:0] fill_count,
    output logic          overflow,
    output logic          hi_alert,
    output logic          lo_alert,
    output logic          irq
);
    logic          wr_en, rd_en;
    logic [DW-1:0] wr_data, head_data;

    wmfifo_access #(.DW(DW)) u_access (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_kind(cmd_kind), .cmd_done(cmd_done),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .eng_wr(eng_wr), .eng_wdata(eng_wdata), .eng_rd(eng_rd),
        .head_data(head_data),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .host_rdata(host_rdata)
    );

    wmfifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .head_data(head_data), .count(fill_count), .overflow(overflow)
    );

    wmfifo_status #(.DEPTH(DEPTH)) u_status (
        .count(fill_count), .water_level(water_level),
        .lo_irq_en(lo_irq_en), .hi_irq_en(hi_irq_en),
        .hi_alert(hi_alert), .lo_alert(lo_alert), .irq(irq)
    );

    assign eng_rdata = head_data;
endmodule

// File: rtl/wmfifo_chk.sv
module wmfifo_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          lo_irq_en,
    input logic          hi_irq_en,
    input logic [CW-1:0] fill_count,
    input logic          overflow,
    input logic          hi_alert,
    input logic          lo_alert,
    input logic          irq
);
    // R3
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill_count == '0) && !overflow);

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);

    // R4
    ovf_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !overflow && fill_count != CW'(DEPTH)) |=> !overflow);

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(DEPTH));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (int'(fill_count) - int'($past(fill_count)) <= 1) &&
                   (int'($past(fill_count)) - int'(fill_count) <= 1));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_irq_en && !hi_irq_en) |-> !irq);

    // R9
    irq_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_irq_en && lo_alert) |-> irq);

    // R8
    lo_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> lo_alert);

    // R7
    hi_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == CW'(DEPTH)) |-> hi_alert);
endmodule

bind wmfifo_top wmfifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lo_irq_en(lo_irq_en), .hi_irq_en(hi_irq_en),
    .fill_count(fill_count), .overflow(overflow),
    .hi_alert(hi_alert), .lo_alert(lo_alert), .irq(irq)
);

// File: tb/wmfifo_top_tb.sv
module wmfifo_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       cmd_start = 1'b0;
    logic [1:0] cmd_kind = 2'b00;
    logic       cmd_done = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, eng_wr = 1'b0, eng_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00, eng_wdata = 8'h00;
    logic [7:0] host_rdata, eng_rdata;
    logic [5:0] water_level = 6'd5;
    logic       lo_irq_en = 1'b0, hi_irq_en = 1'b0;
    logic [6:0] fill_count;
    logic       overflow, hi_alert, lo_alert, irq;

    int checks = 0;
    int failures = 0;
    logic [7:0] pre_host, pre_eng;

    always #(CLK_PERIOD/2) clk = ~clk;

    wmfifo_top u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cmd_start(cmd_start), .cmd_kind(cmd_kind), .cmd_done(cmd_done),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata),
        .eng_wr(eng_wr), .eng_wdata(eng_wdata), .eng_rd(eng_rd),
        .eng_rdata(eng_rdata),
        .water_level(water_level), .lo_irq_en(lo_irq_en), .hi_irq_en(hi_irq_en),
        .fill_count(fill_count), .overflow(overflow),
        .hi_alert(hi_alert), .lo_alert(lo_alert), .irq(irq)
    );

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] wd;
        logic [7:0] exp_rd;
        logic [6:0] exp_cnt;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 8'hA1, 8'h00, 7'd1},
        '{1'b1, 1'b0, 8'hB2, 8'h00, 7'd2},
        '{1'b1, 1'b0, 8'hC3, 8'h00, 7'd3},
        '{1'b0, 1'b1, 8'h00, 8'hA1, 7'd2},
        '{1'b1, 1'b1, 8'hD4, 8'hB2, 7'd2},
        '{1'b0, 1'b1, 8'h00, 8'hC3, 7'd1},
        '{1'b0, 1'b1, 8'h00, 8'hD4, 7'd0},
        '{1'b0, 1'b1, 8'h00, 8'h00, 7'd0},
        '{1'b1, 1'b1, 8'hE5, 8'h00, 7'd1},
        '{1'b0, 1'b1, 8'h00, 8'hE5, 7'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one cycle of accesses; sample read data before the edge
    task automatic step(input logic hw, input logic [7:0] hd, input logic hr,
                        input logic ew, input logic [7:0] ed, input logic er);
        @(negedge clk);
        host_wr = hw; host_wdata = hd; host_rd = hr;
        eng_wr = ew; eng_wdata = ed; eng_rd = er;
        #1;
        pre_host = host_rdata;
        pre_eng  = eng_rdata;
        @(posedge clk);
        #1;
        host_wr = 1'b0; host_rd = 1'b0; eng_wr = 1'b0; eng_rd = 1'b0;
    endtask

    task automatic cmd(input logic st, input logic [1:0] kind, input logic dn);
        @(negedge clk);
        cmd_start = st; cmd_kind = kind; cmd_done = dn;
        @(posedge clk);
        #1;
        cmd_start = 1'b0; cmd_done = 1'b0; cmd_kind = 2'b00;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        #1;
        flush = 1'b0;
    endtask

    task automatic chk_flags(input string req, input int cnt);
        chk({req, " lo_alert"}, lo_alert, (cnt <= water_level) ? 1 : 0);
        chk({req, " hi_alert"}, hi_alert, ((DEPTH - cnt) <= water_level) ? 1 : 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 count", fill_count, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 lo_alert", lo_alert, 1);
        chk("R1 hi_alert", hi_alert, 0);
        chk("R1 irq", irq, 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 count after release", fill_count, 0);

        // R2 R5 R6 R8 R13 vector walk
        water_level = 6'd2;
        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].wr, VECS[i].wd, VECS[i].rd, 1'b0, 8'h00, 1'b0);
            if (VECS[i].rd) chk("R2/R5 read data", pre_host, VECS[i].exp_rd);
            chk("R2/R6 count", fill_count, VECS[i].exp_cnt);
            chk_flags("R8/R13", VECS[i].exp_cnt);
        end

        // R9 gating on near-empty
        lo_irq_en = 1'b1; #1;
        chk("R9 irq lo enabled", irq, 1);
        lo_irq_en = 1'b0; #1;
        chk("R9 irq lo disabled", irq, 0);
        hi_irq_en = 1'b1; #1;
        chk("R9 irq hi enabled, no hi alert", irq, 0);

        // R7 fill toward full
        for (int i = 0; i < 61; i++) step(1'b1, 8'(i + 16), 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R7 count 61", fill_count, 61);
        chk("R7 hi below threshold", hi_alert, 0);
        chk("R9 irq idle", irq, 0);
        step(1'b1, 8'(61 + 16), 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R7 hi at free=2", hi_alert, 1);
        chk("R9 irq hi", irq, 1);
        step(1'b1, 8'(62 + 16), 1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b1, 8'(63 + 16), 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R2 count full", fill_count, 64);
        chk("R4 no overflow yet", overflow, 0);

        // R4 overflow on write at full
        step(1'b1, 8'hEE, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R4 count stays", fill_count, 64);
        chk("R4 overflow set", overflow, 1);

        // R6 push and pop at full
        step(1'b1, 8'hAA, 1'b1, 1'b0, 8'h00, 1'b0);
        chk("R6 head at full", pre_host, 8'h10);
        chk("R6 count at full", fill_count, 64);
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        chk("R4 discarded byte skipped", pre_host, 8'h11);
        chk("R2 count 63", fill_count, 63);
        chk("R4 overflow sticky", overflow, 1);

        // R3 flush beats a same-cycle write
        @(negedge clk);
        flush = 1'b1; host_wr = 1'b1; host_wdata = 8'h99;
        @(posedge clk);
        #1;
        flush = 1'b0; host_wr = 1'b0;
        chk("R3 count cleared", fill_count, 0);
        chk("R3 overflow cleared", overflow, 0);
        chk("R3 lo alert", lo_alert, 1);
        step(1'b1, 8'h5A, 1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        chk("R3 fresh data", pre_host, 8'h5A);
        hi_irq_en = 1'b0;

        // R10 R11 argument load
        cmd(1'b1, 2'b01, 1'b0);
        step(1'b1, 8'h33, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R11 host write accepted", fill_count, 1);
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        chk("R11 host read data", pre_host, 8'h00);
        chk("R11 host read no pop", fill_count, 1);
        step(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1);
        chk("R11 engine read", pre_eng, 8'h33);
        chk("R11 engine pop", fill_count, 0);
        cmd(1'b1, 2'b10, 1'b0);
        step(1'b1, 8'h44, 1'b1, 1'b0, 8'h00, 1'b0);
        chk("R10 start ignored when busy", fill_count, 1);
        cmd(1'b0, 2'b00, 1'b1);
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        chk("R10 done to idle read", pre_host, 8'h44);
        chk("R10 done to idle count", fill_count, 0);
        cmd(1'b1, 2'b00, 1'b0);
        step(1'b1, 8'h55, 1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        chk("R10 bad kind stays idle", pre_host, 8'h55);
        cmd(1'b1, 2'b10, 1'b0);
        step(1'b1, 8'h66, 1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        chk("R10 stream host read", pre_host, 8'h66);

        // R12 engine priority
        step(1'b1, 8'h77, 1'b0, 1'b1, 8'h88, 1'b0);
        chk("R12 one write", fill_count, 1);
        step(1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1);
        chk("R12 host read dropped", pre_host, 8'h00);
        chk("R12 engine read", pre_eng, 8'h88);
        chk("R12 single pop", fill_count, 1);
        cmd(1'b0, 2'b00, 1'b1);
        do_flush();
        chk("R3 final flush", fill_count, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule